// File: doc/BRIEF.md
# Programmed-Angle H-Bridge Level Sequencer

This block produces the level command for a single H-bridge cell from a small set of precomputed switching angles. The angles are chosen off-chip so that selected harmonics cancel. A phase accumulator advances by a programmable increment on every clock and sweeps one fundamental period. The current phase is folded into the first quarter period and compared against the angles. Because of this fold, the waveform repeats mirrored about 90° and changes sign in the second half period, which makes it quarter-wave symmetric.

One mode bit selects the waveform type. In bipolar operation, each angle crossing flips a square wave, so the output is always +1 or −1. In unipolar operation, each angle crossing switches a pulse on or off. The pulse polarity follows the half period, and the output rests at 0 between pulses. The same angle table drives both modes.

The level is also decoded into the four gate commands of the bridge. A one-cycle pulse marks every crossing of 180° and of 360°. If the angle set is malformed, the output is forced to zero and an error flag is raised.

Top module: `pwm_top`

## Requirements
- R1: While rst_ni is low, level_o is 0, gate_o is 4'b0000, err_o is 0 and half_o is 0.
- R2: The phase register starts at 0 and adds phase_inc_i modulo 2^PHASE_W on every clock. half_o is high for the one cycle that follows an update in which the phase MSB changed, that is, an update that crossed 180° or wrapped at 360°. With a zero increment, half_o stays low.
- R3: The phase p is folded as follows. Let H = 2^(PHASE_W-1), Q = H/2 and r = p mod H. Then x = r when r < Q, and x = H − r otherwise. Angle j counts as crossed when it is active and x ≥ angle j. The output at each clock reflects the phase held before that clock edge.
- R4: Bipolar mode is mode_i = 0. In the first half period (p < H), level_o is +1 when the number of crossed angles is even and −1 when it is odd. In the second half period the sign is inverted. Outside the error state, the level is never 0 in this mode.
- R5: Unipolar mode is mode_i = 1. When the number of crossed angles is odd, level_o is +1 in the first half period and −1 in the second. When that number is even, level_o is 0.
- R6: level_o uses two's complement: 2'b01 is +1, 2'b00 is 0 and 2'b11 is −1. gate_o is {leg A high, leg A low, leg B high, leg B low}. A level of +1 gives 4'b1001, −1 gives 4'b0110 and 0 gives 4'b0101. One leg never has both of its switches on.
- R7: With three active angles and a steady increment, the leg A high switch turns on 7 times per fundamental period in bipolar mode and 3 times in unipolar mode.
- R8: err_o is set and the output is forced to level 0 with gate_o = 4'b0101 in either of these cases:
  - ang_cnt_i exceeds N_ANG;
  - some active angle is not strictly greater than the active angle before it.

  Both outputs update at the next clock.
- R9: Only angle entries 0 to ang_cnt_i−1 are active. Entries at or above ang_cnt_i have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phase_inc_i | input | PHASE_W | Phase step per clock |
| mode_i | input | 1 | 0 bipolar, 1 unipolar |
| ang_cnt_i | input | CNT_W | Number of active angles |
| angles_i | input | N_ANG x ANG_W | Switching angles in first-quarter phase units, ascending |
| level_o | output | 2 | Level command, two's complement |
| gate_o | output | 4 | Switch commands {A high, A low, B high, B low} |
| err_o | output | 1 | Angle set invalid |
| half_o | output | 1 | Half-period crossing pulse |

## Verification
The bench builds the block with PHASE_W = 12 and N_ANG = 4. With these values a quarter period spans 1024 phase units, and a full period takes 1024 clocks at an increment of 4. This keeps whole-period switching counts and several mode and angle-set changes within a short run. An increment of half the period makes half_o fire on every clock, and an increment of zero freezes the phase. The error path is driven both by a descending angle pair and by an angle count above four. A case with two active angles and garbage in the inactive entries shows that those entries are ignored.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_POS  = 2'b01,
    LVL_NEG  = 2'b11
  } level_e;

  localparam logic [3:0] GATE_OFF  = 4'b0000;
  localparam logic [3:0] GATE_POS  = 4'b1001;
  localparam logic [3:0] GATE_NEG  = 4'b0110;
  localparam logic [3:0] GATE_ZERO = 4'b0101;

  function automatic logic [3:0] gate_of(level_e lvl);
    case (lvl)
      LVL_POS: gate_of = GATE_POS;
      LVL_NEG: gate_of = GATE_NEG;
      default: gate_of = GATE_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/pwm_phase_accum.sv
module pwm_phase_accum #(
  parameter int PHASE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] inc_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               half_o
);

  logic [PHASE_W-1:0] phase_q, phase_d;
  logic               half_q;

  assign phase_d = phase_q + inc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      half_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      half_q  <= phase_d[PHASE_W-1] ^ phase_q[PHASE_W-1];
    end
  end

  assign phase_o = phase_q;
  assign half_o  = half_q;

endmodule

// File: rtl/pwm_angle_check.sv
module pwm_angle_check #(
  parameter int N_ANG = 4,
  parameter int ANG_W = 14,
  parameter int CNT_W = 3
) (
  input  logic [N_ANG-1:0][ANG_W-1:0] angles_i,
  input  logic [CNT_W-1:0]            cnt_i,
  output logic                        bad_o
);

  logic [N_ANG-1:0] desc;

  assign desc[0] = 1'b0;

  for (genvar j = 1; j < N_ANG; j++) begin : g_pair
    assign desc[j] = (cnt_i > CNT_W'(j)) && (angles_i[j] <= angles_i[j-1]);
  end

  assign bad_o = (cnt_i > CNT_W'(N_ANG)) || (|desc);

endmodule

// File: rtl/pwm_wave_shaper.sv
module pwm_wave_shaper
  import pwm_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int N_ANG   = 4,
  parameter int ANG_W   = PHASE_W - 2,
  parameter int CNT_W   = 3
) (
  input  logic [PHASE_W-1:0]          phase_i,
  input  logic [N_ANG-1:0][ANG_W-1:0] angles_i,
  input  logic [CNT_W-1:0]            cnt_i,
  input  logic                        mode_i,
  output level_e                      level_o
);

  localparam logic [PHASE_W-1:0] HALF = PHASE_W'(1) << (PHASE_W - 1);

  logic               neg_half;
  logic [PHASE_W-1:0] in_half, folded;
  logic [N_ANG-1:0]   crossed;
  logic               odd;

  assign neg_half = phase_i[PHASE_W-1];
  assign in_half  = {1'b0, phase_i[PHASE_W-2:0]};
  // second quarter mirrors about 90 degrees
  assign folded   = phase_i[PHASE_W-2] ? (HALF - in_half) : in_half;

  for (genvar j = 0; j < N_ANG; j++) begin : g_cmp
    assign crossed[j] = (cnt_i > CNT_W'(j)) &&
                        (folded >= {2'b00, angles_i[j]});
  end

  assign odd = ^crossed;

  always_comb begin
    if (mode_i) begin
      if (!odd)          level_o = LVL_ZERO;
      else if (neg_half) level_o = LVL_NEG;
      else               level_o = LVL_POS;
    end else begin
      level_o = (odd ^ neg_half) ? LVL_NEG : LVL_POS;
    end
  end

endmodule

// File: rtl/pwm_top.sv
module pwm_top
  import pwm_pkg::*;
#(
  parameter int  PHASE_W = 16,
  parameter int  N_ANG   = 4,
  localparam int ANG_W   = PHASE_W - 2,
  localparam int CNT_W   = $clog2(N_ANG + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [PHASE_W-1:0]          phase_inc_i,
  input  logic                        mode_i,
  input  logic [CNT_W-1:0]            ang_cnt_i,
  input  logic [N_ANG-1:0][ANG_W-1:0] angles_i,
  output logic [1:0]                  level_o,
  output logic [3:0]                  gate_o,
  output logic                        err_o,
  output logic                        half_o
);

  logic [PHASE_W-1:0] phase;
  logic               bad;
  level_e             shaped, level_d;
  logic [1:0]         level_q;
  logic [3:0]         gate_q;
  logic               err_q;

  pwm_phase_accum #(.PHASE_W(PHASE_W)) u_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (phase_inc_i),
    .phase_o (phase),
    .half_o  (half_o)
  );

  pwm_angle_check #(.N_ANG(N_ANG), .ANG_W(ANG_W), .CNT_W(CNT_W)) u_check (
    .angles_i (angles_i),
    .cnt_i    (ang_cnt_i),
    .bad_o    (bad)
  );

  pwm_wave_shaper #(
    .PHASE_W(PHASE_W), .N_ANG(N_ANG), .ANG_W(ANG_W), .CNT_W(CNT_W)
  ) u_shaper (
    .phase_i  (phase),
    .angles_i (angles_i),
    .cnt_i    (ang_cnt_i),
    .mode_i   (mode_i),
    .level_o  (shaped)
  );

  assign level_d = bad ? LVL_ZERO : shaped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= LVL_ZERO;
      gate_q  <= GATE_OFF;
      err_q   <= 1'b0;
    end else begin
      level_q <= level_d;
      gate_q  <= gate_of(level_d);
      err_q   <= bad;
    end
  end

  assign level_o = level_q;
  assign gate_o  = gate_q;
  assign err_o   = err_q;

endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
  parameter int PHASE_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [PHASE_W-1:0] phase_inc_i,
  input logic               mode_i,
  input logic [1:0]         level_o,
  input logic [3:0]         gate_o,
  input logic               err_o,
  input logic               half_o
);

  logic started;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started <= 1'b0;
    else         started <= 1'b1;
  end

  assert_level_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o != 2'b10);

  assert_no_shoot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_o[3] && gate_o[2]) && !(gate_o[1] && gate_o[0]));

  assert_err_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (level_o == 2'b00 && gate_o == 4'b0101));

  assert_bip_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && !$past(mode_i) && !err_o) |-> level_o != 2'b00);

  assert_half_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && $past(phase_inc_i) == '0) |-> !half_o);

endmodule

bind pwm_top pwm_checker #(.PHASE_W(PHASE_W)) u_pwm_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .phase_inc_i (phase_inc_i),
  .mode_i      (mode_i),
  .level_o     (level_o),
  .gate_o      (gate_o),
  .err_o       (err_o),
  .half_o      (half_o)
);

// File: tb/tb_pwm_top.sv
`timescale 1ns/1ps
module tb_pwm_top;

  localparam int W   = 12;
  localparam int NA  = 4;
  localparam int AW  = W - 2;
  localparam int CW  = $clog2(NA + 1);
  localparam int PER = 1 << W;
  localparam int H   = PER / 2;
  localparam int Q   = PER / 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [W-1:0]         inc = '0;
  logic                 mode = 1'b0;
  logic [CW-1:0]        cnt = '0;
  logic [NA-1:0][AW-1:0] ang = '0;
  logic [1:0]           level_o;
  logic [3:0]           gate_o;
  logic                 err_o, half_o;

  int    checks = 0, errors = 0;
  string cur_req = "R4";
  bit    chk_en = 1'b0;
  bit    done = 1'b0;

  int p;
  int exp_lvl, exp_half, exp_err;
  logic [3:0] exp_gate;

  always #2 clk = ~clk;

  pwm_top #(.PHASE_W(W), .N_ANG(NA)) dut (
    .clk_i(clk), .rst_ni(rst_n), .phase_inc_i(inc), .mode_i(mode),
    .ang_cnt_i(cnt), .angles_i(ang), .level_o(level_o), .gate_o(gate_o),
    .err_o(err_o), .half_o(half_o)
  );

  // behavioural reference, one register stage
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p = 0; exp_lvl = 0; exp_gate = 4'b0000; exp_err = 0; exp_half = 0;
    end else begin
      int k, r, x, nxt;
      bit bad, neg;
      int act[$];
      act = {};
      for (int j = 0; j < NA && j < int'(cnt); j++) act.push_back(int'(ang[j]));
      bad = (int'(cnt) > NA);
      for (int j = 1; j < act.size(); j++) if (act[j] <= act[j-1]) bad = 1;
      neg = (p >= H);
      r = p % H;
      x = (r < Q) ? r : H - r;
      k = 0;
      foreach (act[j]) if (x >= act[j]) k++;
      if (bad) exp_lvl = 0;
      else if (mode) exp_lvl = (k % 2 == 1) ? (neg ? -1 : 1) : 0;
      else exp_lvl = (((k % 2) == 1) != neg) ? -1 : 1;
      exp_gate = (exp_lvl == 1) ? 4'b1001 : (exp_lvl == -1) ? 4'b0110 : 4'b0101;
      exp_err = bad ? 1 : 0;
      nxt = (p + int'(inc)) % PER;
      exp_half = ((nxt >= H) != neg) ? 1 : 0;
      p = nxt;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && rst_n) begin
      chk(cur_req, int'($signed(level_o)), exp_lvl);
      chk("R6", int'(gate_o), int'(exp_gate));
      chk("R2", int'(half_o), exp_half);
      chk("R8", int'(err_o), exp_err);
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_rises(int win, int exp, string req);
    int rises = 0;
    logic prev;
    prev = gate_o[3];
    repeat (win) begin
      @(negedge clk);
      if (gate_o[3] && !prev) rises++;
      prev = gate_o[3];
    end
    chk(req, rises, exp);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    inc = 12'd4; mode = 1'b0; cnt = 3'd3;
    ang[0] = 10'd200; ang[1] = 10'd500; ang[2] = 10'd800; ang[3] = 10'd0;
    run(3);
    // R1: reset values
    chk("R1", int'({level_o, gate_o, err_o, half_o}), 0);
    rst_n = 1'b1;
    chk_en = 1'b1;

    // R4 bipolar, three angles; R7 seven turn-ons per period
    cur_req = "R4";
    run(1100);
    count_rises(1024, 7, "R7");

    // R5 unipolar; R7 three turn-ons per period
    mode = 1'b1; cur_req = "R5";
    run(1100);
    count_rises(1024, 3, "R7");

    // R3 four angles, odd increment, both modes
    cur_req = "R3";
    cnt = 3'd4; inc = 12'd7;
    ang[0] = 10'd100; ang[1] = 10'd300; ang[2] = 10'd600; ang[3] = 10'd1000;
    run(700);
    mode = 1'b0;
    run(700);

    // R9 inactive entries descending garbage
    cur_req = "R9";
    cnt = 3'd2; ang[0] = 10'd250; ang[1] = 10'd700; ang[2] = 10'd9; ang[3] = 10'd3;
    run(600);
    mode = 1'b1;
    run(600);

    // R8 descending active pair, then count above N_ANG
    cur_req = "R8";
    cnt = 3'd3; ang[0] = 10'd500; ang[1] = 10'd200; ang[2] = 10'd800;
    run(300);
    ang[1] = 10'd500;
    run(100);
    ang[0] = 10'd100; ang[1] = 10'd400; ang[2] = 10'd900;
    cnt = 3'd5;
    run(300);
    cnt = 3'd3; cur_req = "R5";
    run(400);

    // R2 half-period step, then frozen phase
    cur_req = "R2";
    inc = 12'd2048; mode = 1'b0;
    run(50);
    inc = 12'd0;
    run(50);
    inc = 12'd4095;
    run(300);

    chk_en = 1'b0;
    done = 1'b1;
    finish_run();
  end

endmodule